// File: doc/BRIEF.md
# Spawn-join virtual thread dispatcher

This block sits between a serial master core and a pool of thread processors. The master issues one spawn command that carries an inclusive range of thread ids. From then on, any processor that wants work raises a request. In the same cycle it receives either the next unused id, taken from a shared counter, or a "no more threads" answer, after which it stays idle. Which processor gets which id depends only on who asks and when, so fast processors simply take more ids than slow ones.

A processor raises its done strobe when the thread it holds reaches the join; that is where the thread ends. The block counts these strobes. Once every id in the range has been handed out and has finished, the block pulses join-complete for one cycle and drops busy, and the master resumes. A second spawn while one is running is refused.

Top module: `thread_dispatch`

## Requirements
- R1: A spawn request while busy_o is low is accepted (spawn_accept_o high in that cycle). busy_o is high from the next cycle and stays high up to and including the cycle in which join_o pulses.
- R2: A spawn request while busy_o is high, including in the join_o cycle, is refused (spawn_reject_o high, spawn_accept_o low). It changes neither the id sequence nor the join timing of the running spawn.
- R3: For bounds lo and hi with hi >= lo, every id from lo to hi is granted exactly once, in increasing order of grant.
- R4: Requests raised in the same cycle are all answered in that cycle. Ids go out by ascending processor index: the k-th requester counted from index 0 receives next+k while ids remain.
- R5: A request gets empty_o instead of grant_o when no ungranted id is left, and also whenever busy_o is low. grant_o and empty_o are combinational responses to req_i in the same cycle.
- R6: join_o is high for exactly one cycle: the first cycle in which the count of done strobes registered since acceptance equals hi-lo+1. That count includes strobes up to the previous cycle. busy_o is low in the following cycle.
- R7: A spawn with hi < lo creates no threads: join_o pulses in the cycle after acceptance, and every request in that cycle gets empty_o.
- R8: Bounds that end at the top of the id range (hi = 2^ID_W - 1) hand out every id up to hi without wrapping around to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spawn_valid_i | input | 1 | Spawn command from the master |
| spawn_lo_i | input | ID_W | Lowest thread id of the spawn |
| spawn_hi_i | input | ID_W | Highest thread id of the spawn |
| spawn_accept_o | output | 1 | Spawn taken this cycle |
| spawn_reject_o | output | 1 | Spawn refused, one already active |
| req_i | input | NPROC | Per-processor request for a thread id |
| grant_o | output | NPROC | Per-processor id granted this cycle |
| empty_o | output | NPROC | Per-processor "no more threads" answer |
| tid_o | output | NPROC*ID_W | Granted id, processor i in bits [i*ID_W +: ID_W] |
| done_i | input | NPROC | Per-processor thread-finished strobe |
| busy_o | output | 1 | Spawn active |
| join_o | output | 1 | One-cycle join-complete pulse |

## Verification
The assertions check on every cycle that join_o never lasts two cycles and that busy only rises after an acceptance. They also check that busy holds through a refused spawn, that the id counter never moves backwards while active, that done strobes never exceed the outstanding grants, and that idle requests get the empty answer. Only the bench's scenarios can show that the full id range is covered exactly once in order, and that same-cycle requesters are ranked by index. They also show the exact join cycle under random processor latencies, the zero-thread and top-of-range bounds, and that a refused spawn leaves the running sequence untouched.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int unsigned DEF_NPROC = 8;
  localparam int unsigned DEF_ID_W  = 16;

  function automatic int unsigned bit_count(input logic [63:0] v);
    int unsigned c;
    c = 0;
    for (int i = 0; i < 64; i++) c += int'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/dispatch_rank.sv
module dispatch_rank #(
  parameter  int unsigned NPROC = dispatch_pkg::DEF_NPROC,
  localparam int unsigned CW    = $clog2(NPROC + 1)
) (
  input  logic [NPROC-1:0]         req_i,
  output logic [NPROC-1:0][CW-1:0] rank_o,
  output logic [CW-1:0]            count_o
);
  // rank of a requester = number of requesters with lower index
  assign rank_o[0] = '0;
  for (genvar g = 1; g < NPROC; g++) begin : g_rank
    assign rank_o[g] = rank_o[g-1] + CW'(req_i[g-1]);
  end
  assign count_o = rank_o[NPROC-1] + CW'(req_i[NPROC-1]);

  // R4
  always_comb begin
    rank_total_chk: assert (int'(count_o) == int'(dispatch_pkg::bit_count(64'(req_i))));
  end
endmodule

// File: rtl/dispatch_cursor.sv
module dispatch_cursor #(
  parameter  int unsigned ID_W = dispatch_pkg::DEF_ID_W,
  parameter  int unsigned CW   = 4,
  localparam int unsigned XW   = ID_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [ID_W-1:0] lo_i,
  input  logic [ID_W-1:0] hi_i,
  input  logic            adv_i,
  input  logic [CW-1:0]   take_i,
  output logic [XW-1:0]   next_o,
  output logic [ID_W-1:0] hi_o
);
  logic [XW-1:0]   next_q;
  logic [ID_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0;
      hi_q   <= '0;
    end else if (load_i) begin
      next_q <= {1'b0, lo_i};
      hi_q   <= hi_i;
    end else if (adv_i) begin
      next_q <= next_q + XW'(take_i);
    end
  end

  assign next_o = next_q;
  assign hi_o   = hi_q;

  // R3
  cursor_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> next_q >= $past(next_q));
endmodule

// File: rtl/dispatch_join.sv
module dispatch_join #(
  parameter  int unsigned NPROC = dispatch_pkg::DEF_NPROC,
  parameter  int unsigned ID_W  = dispatch_pkg::DEF_ID_W,
  parameter  int unsigned CW    = $clog2(NPROC + 1),
  localparam int unsigned XW    = ID_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [ID_W-1:0]  lo_i,
  input  logic [ID_W-1:0]  hi_i,
  input  logic [CW-1:0]    take_i,
  input  logic [NPROC-1:0] done_i,
  output logic             busy_o,
  output logic             join_o
);
  logic          busy_q;
  logic [CW-1:0] out_q;
  logic [XW-1:0] done_q, total_q;
  logic [CW-1:0] ndone;

  always_comb begin
    ndone = '0;
    for (int i = 0; i < NPROC; i++) ndone = ndone + CW'(done_i[i]);
  end

  assign join_o = busy_q && (done_q == total_q) && (out_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      out_q   <= '0;
      done_q  <= '0;
      total_q <= '0;
    end else if (accept_i) begin
      busy_q  <= 1'b1;
      out_q   <= '0;
      done_q  <= '0;
      total_q <= (hi_i >= lo_i) ? ({1'b0, hi_i} - {1'b0, lo_i} + XW'(1)) : '0;
    end else if (join_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      out_q  <= out_q + take_i - ndone;
      done_q <= done_q + XW'(ndone);
    end
  end

  // R6
  join_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    join_o |=> !join_o);
  // R6
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ndone <= out_q);
  // R1
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(accept_i));
  // R1
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !join_o |=> busy_q);
endmodule

// File: rtl/thread_dispatch.sv
module thread_dispatch #(
  parameter  int unsigned NPROC = dispatch_pkg::DEF_NPROC,
  parameter  int unsigned ID_W  = dispatch_pkg::DEF_ID_W,
  localparam int unsigned CW    = $clog2(NPROC + 1),
  localparam int unsigned XW    = ID_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 spawn_valid_i,
  input  logic [ID_W-1:0]      spawn_lo_i,
  input  logic [ID_W-1:0]      spawn_hi_i,
  output logic                 spawn_accept_o,
  output logic                 spawn_reject_o,
  input  logic [NPROC-1:0]     req_i,
  output logic [NPROC-1:0]     grant_o,
  output logic [NPROC-1:0]     empty_o,
  output logic [NPROC*ID_W-1:0] tid_o,
  input  logic [NPROC-1:0]     done_i,
  output logic                 busy_o,
  output logic                 join_o
);
  logic [NPROC-1:0][CW-1:0] rank;
  logic [CW-1:0]            req_cnt, take;
  logic [XW-1:0]            next, avail;
  logic [ID_W-1:0]          hi;
  logic                     busy;

  assign spawn_accept_o = spawn_valid_i && !busy;
  assign spawn_reject_o = spawn_valid_i && busy;

  dispatch_rank #(.NPROC(NPROC)) u_rank (
    .req_i   (req_i),
    .rank_o  (rank),
    .count_o (req_cnt)
  );

  dispatch_cursor #(.ID_W(ID_W), .CW(CW)) u_cursor (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (spawn_accept_o),
    .lo_i   (spawn_lo_i),
    .hi_i   (spawn_hi_i),
    .adv_i  (busy),
    .take_i (take),
    .next_o (next),
    .hi_o   (hi)
  );

  dispatch_join #(.NPROC(NPROC), .ID_W(ID_W), .CW(CW)) u_join (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (spawn_accept_o),
    .lo_i     (spawn_lo_i),
    .hi_i     (spawn_hi_i),
    .take_i   (take),
    .done_i   (done_i),
    .busy_o   (busy),
    .join_o   (join_o)
  );

  assign busy_o = busy;

  // ids left in the range; zero once next passes hi (or for hi < lo)
  always_comb begin
    avail = '0;
    if (busy && (next <= {1'b0, hi})) avail = {1'b0, hi} - next + XW'(1);
  end

  assign take = (XW'(req_cnt) < avail) ? req_cnt : CW'(avail);

  for (genvar g = 0; g < NPROC; g++) begin : g_port
    logic [XW-1:0] sum;
    assign sum        = next + XW'(rank[g]);
    assign grant_o[g] = req_i[g] && (XW'(rank[g]) < avail);
    assign empty_o[g] = req_i[g] && !grant_o[g];
    assign tid_o[g*ID_W +: ID_W] = sum[ID_W-1:0];

    // R5
    idle_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o && req_i[g] |-> empty_o[g]);
  end

  // R2
  reject_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spawn_reject_o && !join_o |=> busy_o);
endmodule

// File: tb/thread_dispatch_test.sv
module thread_dispatch_test;
  localparam int NP = 8;
  localparam int IW = 16;

  logic clk = 0, rst_n = 0;
  logic spawn_valid = 0;
  logic [IW-1:0] spawn_lo = 0, spawn_hi = 0;
  logic spawn_accept, spawn_reject;
  logic [NP-1:0] req = 0, grant, empty, done = 0;
  logic [NP*IW-1:0] tid;
  logic busy, join_p;

  int errors = 0, checks = 0, cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  thread_dispatch uut (
    .clk_i(clk), .rst_ni(rst_n), .spawn_valid_i(spawn_valid),
    .spawn_lo_i(spawn_lo), .spawn_hi_i(spawn_hi),
    .spawn_accept_o(spawn_accept), .spawn_reject_o(spawn_reject),
    .req_i(req), .grant_o(grant), .empty_o(empty), .tid_o(tid),
    .done_i(done), .busy_o(busy), .join_o(join_p)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_total(input int lo, input int hi);
    return (hi >= lo) ? hi - lo + 1 : 0;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one complete spawn; rej_at >= 0 injects a refused spawn in that cycle
  task automatic run_spawn(input int lo, input int hi, input int maxlat, input int rej_at);
    int st[NP];   // 0 wants an id, 1 running, 2 retired
    int cd[NP];
    int nxt, dprev, total, granted, cyc;
    bit ej, fin;
    total = exp_total(lo, hi);
    @(negedge clk);
    spawn_valid = 1; spawn_lo = IW'(lo); spawn_hi = IW'(hi);
    #1;
    chk(spawn_accept == 1 && spawn_reject == 0, "R1 accept", int'(spawn_accept), 1);
    @(posedge clk);
    for (int i = 0; i < NP; i++) begin st[i] = 0; cd[i] = 0; end
    nxt = lo; dprev = 0; granted = 0; cyc = 0; fin = 0;
    while (!fin) begin
      @(negedge clk);
      spawn_valid = 0;
      done = '0; req = '0;
      for (int i = 0; i < NP; i++)
        if (st[i] == 1) begin
          if (cd[i] == 0) begin done[i] = 1; st[i] = 0; end
          else cd[i]--;
        end
      for (int i = 0; i < NP; i++) if (st[i] == 0) req[i] = 1;
      ej = (dprev == total);
      if (ej || cyc == rej_at) begin
        spawn_valid = 1; spawn_lo = 16'h0; spawn_hi = 16'h0003;
      end
      #1;
      chk(busy == 1, "R1 busy while active", int'(busy), 1);
      chk(join_p == ej, ej && total == 0 ? "R7 join" : "R6 join timing", int'(join_p), int'(ej));
      if (spawn_valid)
        chk(spawn_reject == 1 && spawn_accept == 0, "R2 reject", int'(spawn_reject), 1);
      for (int i = 0; i < NP; i++)
        if (req[i]) begin
          if (nxt <= hi) begin
            chk(grant[i] == 1 && empty[i] == 0, "R4 grant", int'(grant[i]), 1);
            chk(int'(tid[i*IW +: IW]) == nxt, hi == 65535 ? "R8 id" : "R3 id", int'(tid[i*IW +: IW]), nxt);
            nxt++; granted++;
            st[i] = 1; cd[i] = $urandom_range(0, maxlat);
          end else begin
            chk(grant[i] == 0 && empty[i] == 1, total == 0 ? "R7 empty" : "R5 empty", int'(empty[i]), 1);
            st[i] = 2;
          end
        end
      for (int i = 0; i < NP; i++) dprev += int'(done[i]);
      cyc++;
      if (ej || cyc > 4000) fin = 1;
    end
    @(negedge clk);
    spawn_valid = 0; done = '0; req = '0;
    #1;
    chk(busy == 0 && join_p == 0, "R6 busy drops after join", int'(busy), 0);
    chk(granted == total, "R3 grant count", granted, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d5e));
    #12;
    chk(busy == 0 && join_p == 0 && spawn_accept == 0, "R1 reset state", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    req = '1;
    #1;
    chk(grant == '0 && empty == '1, "R5 idle request", int'(empty), 255);
    @(negedge clk); req = '0;

    run_spawn(0, 9, 3, -1);
    run_spawn(5, 7, 2, -1);       // fewer ids than requesters
    run_spawn(10, 3, 2, -1);      // zero threads
    run_spawn(3, 3, 0, -1);       // single thread
    run_spawn(100, 140, 5, 4);    // refused spawn mid-run
    run_spawn(65528, 65535, 3, -1);
    run_spawn(65500, 65535, 2, 2);
    for (int k = 0; k < 6; k++) begin
      int lo, hi;
      lo = $urandom_range(0, 300);
      hi = lo + $urandom_range(0, 60) - 3;
      if (hi < 0) hi = 0;
      run_spawn(lo, hi, $urandom_range(0, 6), $urandom_range(0, 1) == 1 ? 1 : -1);
    end
    finish_run();
  end
endmodule